// File: doc/BRIEF.md
# Capture and Reload Down-Counter Timer

This block is a down-counting timer for measuring intervals between external events. A power-of-two prescaler paces each decrement. Two event inputs each pass through a two-flop synchronizer, followed by an edge detector whose active polarity is programmable. A simple write port reaches three registers: control, reload value and status. The status register holds an event flag and an overrun error flag for each input, and software clears them by writing ones.

With reload disabled, the counter runs freely and wraps around. In that mode, an edge on the first input copies the count into the reload register, and an edge on the second input copies the count into the capture register.

With reload enabled, the counter restarts from the reload register. A source field picks what triggers the restart: a software write, an edge on the first input, or an edge on the second input. Edges on the second input still capture the count. A capture that arrives while the previous one is unacknowledged does not overwrite it; instead it raises the overrun flag. When a capture and a reload fall in the same cycle, the capture records the count from before the reload.

Register map on `wr_addr`:
- 0: control. Bit 0 is run. Bit 1 is reload enable. Bits 3:2 are the source select. Bit 4 is the first input's polarity and bit 5 is the second input's polarity (1 means rising, 0 means falling). Bits 8:6 are the prescaler exponent.
- 1: reload value.
- 2: status, write 1 to clear.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, capture and reload registers and all flags are 0. While reload enable is 0, the counter decrements by one per prescaler tick, wraps from 0000h to FFFFh, and no event edge changes it other than by that decrement.
- R2: The prescaler exponent p (control bits 8:6) divides by 2^p, with p from 0 to 7. A control write restarts the prescaler phase, so that after it the counter has dropped by floor(N/2^p) once N more rising clock edges have passed.
- R3: While run (control bit 0) is 0, the counter holds, and edges on both inputs set no flag and make no capture.
- R4: With reload enable set and source 00 or 11, a control write with run set loads the reload value into the counter on the rising edge that follows the write edge. Counting then continues from that value.
- R5: With reload enable set and source 01, every active edge on the first input loads the counter from the reload register and sets flag bit 0. If bit 0 is already set at that moment, error bit 1 is set as well.
- R6: With reload enable set and source 10, every active edge on the second input loads the counter from the reload register. Edges on the first input have no effect in this mode.
- R7: An active edge on the second input while running, with status bits 2 and 3 both clear, copies the pre-edge count into the capture register and sets bit 2.
- R8: An active edge on the second input while bit 2 or bit 3 is set sets bit 3 and leaves the capture register unchanged. Captures resume only once both bits are cleared.
- R9: While reload enable is set, only a write to address 1 changes the reload register. While reload enable is 0, an active edge on the first input copies the count into the reload register, with the same lockout on bits 0 and 1 that R8 gives bits 2 and 3.
- R10: If a capture and a reload happen in the same cycle, the capture register receives the count from before the reload.
- R11: Control bits 4 and 5 pick the active edge of the first and second inputs, 1 meaning rising and 0 meaning falling. An edge of the other direction has no effect.
- R12: A change on an event input takes effect at the third rising clock edge after it, and not earlier.
- R13: A write to address 2 clears each status bit whose data bit is 1 and leaves the others unchanged. Status bits are {err2, flag2, err1, flag1} from bit 3 down to bit 0. An event that sets a bit in the same cycle as a clear takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 reload, 2 status) |
| wr_data | input | 16 | Write data |
| ev1_in | input | 1 | First event input, asynchronous (reload trigger / reload-register capture) |
| ev2_in | input | 1 | Second event input, asynchronous (capture trigger / optional reload trigger) |
| cnt_o | output | 16 | Live count |
| cap_o | output | 16 | Capture register |
| rld_o | output | 16 | Reload register |
| flags_o | output | 4 | Status {err2, flag2, err1, flag1} |

## Verification
An event input driven at a falling clock edge acts at the third rising edge after it. The bench therefore reads the live count after the second rising edge, which is the value the capture must hold. It then checks the capture, the count and the flags after the third edge, and it also confirms that nothing has changed after only two edges. A software restart shows up one rising edge after the write edge. Prescaled counts are checked a fixed number of edges after the control write that resets the phase, using floor(N/2^p).

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PSC_SEL_W = 3;
  localparam int PHASE_W   = (1 << PSC_SEL_W) - 1;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RLD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    SRC_SW     = 2'b00,
    SRC_EV1    = 2'b01,
    SRC_EV2    = 2'b10,
    SRC_SW_ALT = 2'b11
  } src_e;

  typedef struct packed {
    logic [PSC_SEL_W-1:0] psc;
    logic                 pol2;
    logic                 pol1;
    src_e                 src;
    logic                 reload_en;
    logic                 run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // true when the phase counter has reached the last step of a 2^sel period
  function automatic logic psc_hit(input logic [PHASE_W-1:0] ph,
                                   input logic [PSC_SEL_W-1:0] sel);
    logic [PHASE_W-1:0] m;
    m = PHASE_W'((1 << sel) - 1);
    return (ph & m) == m;
  endfunction

  function automatic logic is_sw_src(input src_e s);
    return (s == SRC_SW) || (s == SRC_SW_ALT);
  endfunction
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_act,
  output logic hit
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], din};
  end

  logic cur, prv;
  assign cur = sh[SYNC_STAGES-1];
  assign prv = sh[SYNC_STAGES];
  assign hit = rise_act ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 restart,
  input  logic [PSC_SEL_W-1:0] sel,
  output logic                 tick
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= phase + 1'b1;
  end

  assign tick = run && !restart && psc_hit(phase, sel);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic lock_mode,
  input  logic clr_flg,
  input  logic clr_err,
  output logic flg,
  output logic err,
  output logic take
);
  logic busy, err_set;

  assign busy    = flg | err;
  assign take    = evt && (!lock_mode || !busy);
  assign err_set = evt && (lock_mode ? busy : flg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= 1'b0;
      err <= 1'b0;
    end else begin
      flg <= take    | (flg & ~clr_flg);
      err <= err_set | (err & ~clr_err);
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ev1_in,
  input  logic             ev2_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [3:0]       flags_o
);
  localparam int NCH = 2;

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  ctrl_t            ctrl_q, ctrl_wr;
  logic [CNT_W-1:0] cnt_q, cap_q, rld_q;
  logic             sw_kick_q;

  logic wr_ctrl, wr_rld, wr_stat;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_rld  = wr_en && (wr_addr == ADDR_RLD);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
  assign ctrl_wr = ctrl_t'(wr_data[CTRL_W-1:0]);

  logic run_q, reload_en_q;
  assign run_q       = ctrl_q.run;
  assign reload_en_q = ctrl_q.reload_en;

  // event channels: index 0 = first input, 1 = second input
  logic [NCH-1:0] ev_pin, ev_pol, edge_hit, ch_evt, ch_lock;
  logic [NCH-1:0] ch_take, ch_flg, ch_err, clr_flg, clr_err;
  assign ev_pin = {ev2_in, ev1_in};
  assign ev_pol = {ctrl_q.pol2, ctrl_q.pol1};

  assign ch_evt[0]  = run_q && edge_hit[0] && (!reload_en_q || ctrl_q.src == SRC_EV1);
  assign ch_evt[1]  = run_q && edge_hit[1];
  assign ch_lock[0] = !reload_en_q;
  assign ch_lock[1] = 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(ev_pin[i]), .rise_act(ev_pol[i]), .hit(edge_hit[i])
    );
    assign clr_flg[i] = wr_stat && wr_data[2*i];
    assign clr_err[i] = wr_stat && wr_data[2*i+1];
    tmr_flag_unit u_flag (
      .clk(clk), .rst_n(rst_n), .evt(ch_evt[i]), .lock_mode(ch_lock[i]),
      .clr_flg(clr_flg[i]), .clr_err(clr_err[i]),
      .flg(ch_flg[i]), .err(ch_err[i]), .take(ch_take[i])
    );
  end

  // named internal events
  logic reload_fire, cap2_fire, rld_cap_fire, tick, psc_restart;
  assign reload_fire = run_q && reload_en_q &&
                       ((sw_kick_q && is_sw_src(ctrl_q.src)) ||
                        (ch_evt[0] && ctrl_q.src == SRC_EV1) ||
                        (ch_evt[1] && ctrl_q.src == SRC_EV2));
  assign cap2_fire    = ch_take[1];
  assign rld_cap_fire = ch_take[0] && !reload_en_q;
  assign psc_restart  = wr_ctrl || reload_fire;

  tmr_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(psc_restart),
    .sel(ctrl_q.psc), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      sw_kick_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_wr;
      sw_kick_q <= wr_ctrl && ctrl_wr.run && ctrl_wr.reload_en && is_sw_src(ctrl_wr.src);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (reload_fire)  cnt_q <= rld_q;
    else if (tick)         cnt_q <= count_step(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cap_q <= '0;
    else if (cap2_fire)  cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rld_q <= '0;
    else if (wr_rld)        rld_q <= wr_data;
    else if (rld_cap_fire)  rld_q <= cnt_q;
  end

  assign cnt_o   = cnt_q;
  assign cap_o   = cap_q;
  assign rld_o   = rld_q;
  assign flags_o = {ch_err[1], ch_flg[1], ch_err[0], ch_flg[0]};
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic [CNT_W-1:0] rld_q,
  input logic [3:0]       flags_o,
  input logic             run_q,
  input logic             reload_en_q,
  input logic             wr_rld,
  input logic             wr_stat,
  input logic [1:0]       ch_evt,
  input logic             cap2_fire,
  input logic             reload_fire
);
  a_r1_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_en_q |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_stat) |=> $stable(cnt_q) && $stable(cap_q) && $stable(flags_o));

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> cnt_q == $past(rld_q));

  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt[0] && flags_o[0]) |=> flags_o[1]);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap2_fire |=> (cap_q == $past(cnt_q)) && flags_o[2]);

  a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt[1] && (flags_o[2] || flags_o[3])) |=> flags_o[3] && $stable(cap_q));

  a_r9_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_en_q && !wr_rld) |=> $stable(rld_q));

  a_r10_capture_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cap2_fire && reload_fire) |=> (cap_q == $past(cnt_q)) && (cnt_q == $past(rld_q)));
endmodule

bind cap_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cap_q(cap_q), .rld_q(rld_q),
  .flags_o(flags_o), .run_q(run_q), .reload_en_q(reload_en_q), .wr_rld(wr_rld),
  .wr_stat(wr_stat), .ch_evt(ch_evt), .cap2_fire(cap2_fire), .reload_fire(reload_fire)
);

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ev1 = 1'b0, ev2 = 1'b0;
  logic [15:0] cnt_o, cap_o, rld_o;
  logic [3:0]  flags_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev1_in(ev1), .ev2_in(ev2), .cnt_o(cnt_o), .cap_o(cap_o), .rld_o(rld_o),
    .flags_o(flags_o)
  );

  function automatic logic [15:0] mk(input logic run, input logic ren, input logic [1:0] sel,
                                     input logic p1, input logic p2, input logic [2:0] psc);
    return {7'd0, psc, p2, p1, sel, ren, run};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, c0;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    chk("R1 reset cnt", cnt_o, 0);
    chk("R1 reset cap", cap_o, 0);
    chk("R1 reset rld", rld_o, 0);
    chk("R13 reset flags", flags_o, 0);

    // R3: not running, edges of both directions ignored
    ev1 = 1; ticks(4); ev2 = 1; ticks(4); ev1 = 0; ev2 = 0; ticks(4);
    chk("R3 idle cnt", cnt_o, 0);
    chk("R3 idle cap", cap_o, 0);
    chk("R3 idle flags", flags_o, 0);

    // R1: wrap
    wr(0, mk(1, 0, 2'b00, 1, 1, 3'd0));
    chk("R1 start cnt", cnt_o, 0);
    ticks(1);
    chk("R1 wrap", cnt_o, 16'hFFFF);

    // R2: prescaler sweep
    for (int p = 0; p < 8; p++) begin
      int d;
      d = 1 << p;
      wr(0, mk(1, 0, 2'b00, 1, 1, 3'(p)));
      c0 = cnt_o;
      ticks(3 * d + d / 2);
      chk($sformatf("R2 psc=%0d", p), cnt_o, 16'(c0 - 16'd3));
    end

    // free mode, psc 0: second input captures, no reload (R1, R7)
    wr(0, mk(1, 0, 2'b00, 1, 1, 3'd0));
    ev2 = 1; ticks(2); v = cnt_o; ticks(1);
    chk("R7 free capture", cap_o, v);
    chk("R1 no reload", cnt_o, 16'(v - 16'd1));
    chk("R7 flag2", flags_o, 4'b0100);
    wr(2, 16'hF); ev2 = 0; ticks(4);

    // R9: first input captures into reload register in free mode
    ev1 = 1; ticks(2); v = cnt_o; ticks(1);
    chk("R9 free rld capture", rld_o, v);
    chk("R9 flag1", flags_o, 4'b0001);
    wr(2, 16'hF); ev1 = 0; ticks(4);

    // R4: software restart
    wr(1, 16'h1234);
    wr(0, mk(1, 1, 2'b00, 1, 1, 3'd0));
    ticks(1);
    chk("R4 sw reload", cnt_o, 16'h1234);
    ticks(1);
    chk("R4 continues", cnt_o, 16'h1233);

    // R5: first-input restart
    wr(1, 16'h0100);
    wr(0, mk(1, 1, 2'b01, 1, 1, 3'd0));
    ev1 = 1; ticks(3);
    chk("R5 reload", cnt_o, 16'h0100);
    chk("R5 flag", flags_o, 4'b0001);
    chk("R9 rld kept", rld_o, 16'h0100);
    ev1 = 0; ticks(5);
    chk("R11 falling ignored", cnt_o, 16'h00FB);
    ev1 = 1; ticks(3);
    chk("R5 second reload", cnt_o, 16'h0100);
    chk("R5 overrun", flags_o, 4'b0011);
    chk("R9 rld kept 2", rld_o, 16'h0100);
    wr(2, 16'h3);
    chk("R13 clear", flags_o, 4'b0000);

    // R7 / R8: capture lockout
    ev2 = 1; ticks(2); v = cnt_o; ticks(1);
    chk("R7 capture", cap_o, v);
    chk("R7 flag", flags_o, 4'b0100);
    ev2 = 0; ticks(4); ev2 = 1; ticks(3);
    chk("R8 locked cap", cap_o, v);
    chk("R8 err", flags_o, 4'b1100);
    wr(2, 16'h4);
    chk("R13 partial clear", flags_o, 4'b1000);
    ev2 = 0; ticks(4); ev2 = 1; ticks(3);
    chk("R8 still locked cap", cap_o, v);
    chk("R8 still err", flags_o, 4'b1000);
    wr(2, 16'hC);
    ev2 = 0; ticks(4); ev2 = 1; ticks(2); v2 = cnt_o; ticks(1);
    chk("R8 resumed cap", cap_o, v2);
    chk("R8 resumed flags", flags_o, 4'b0100);
    wr(2, 16'hF); ev2 = 0; ev1 = 0; ticks(4);

    // R10: simultaneous capture and reload
    ev1 = 1; ev2 = 1; ticks(2); v = cnt_o; ticks(1);
    chk("R10 capture pre-reload", cap_o, v);
    chk("R10 reloaded", cnt_o, 16'h0100);
    wr(2, 16'hF); ev1 = 0; ev2 = 0; ticks(4);

    // R11: falling polarity on second input
    wr(0, mk(1, 1, 2'b01, 1, 0, 3'd0));
    ev2 = 1; ticks(4);
    chk("R11 rising ignored cap", cap_o, v);
    chk("R11 rising ignored flags", flags_o, 0);
    ev2 = 0; ticks(2); v = cnt_o; ticks(1);
    chk("R11 falling capture", cap_o, v);
    wr(2, 16'hF);

    // R6: second-input restart
    wr(1, 16'h0800);
    wr(0, mk(1, 1, 2'b10, 1, 1, 3'd0));
    ev2 = 1; ticks(2); v = cnt_o; ticks(1);
    chk("R6 reload", cnt_o, 16'h0800);
    chk("R6 capture", cap_o, v);
    wr(2, 16'hF);
    ev1 = 1; ticks(3);
    chk("R6 first input ignored", flags_o, 0);
    chk("R9 rld unchanged", rld_o, 16'h0800);

    // R4: alternate software source
    wr(1, 16'h0042);
    wr(0, mk(1, 1, 2'b11, 1, 1, 3'd0));
    ticks(1);
    chk("R4 alt sw reload", cnt_o, 16'h0042);

    // R12: latency of three rising edges
    wr(0, mk(1, 0, 2'b00, 1, 1, 3'd0));
    wr(2, 16'hF);
    ev2 = 0; ticks(4);
    ev2 = 1; ticks(2);
    chk("R12 not yet", flags_o, 0);
    ticks(1);
    chk("R12 third edge", flags_o, 4'b0100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule